// File: doc/BRIEF.md
# Inverted Page Table Translator with Per-Process Rights

This block sits in front of one on-chip RAM region and turns a virtual address, issued on behalf of a process, into a physical address, or refuses it. The mapping lives in a sixteen-slot table whose slots stand for physical pages. Each slot names the virtual page that lands on it and a three-bit rights code saying which unprivileged process may use it. Translation therefore searches every slot for the requested virtual page rather than indexing by it. Processes 0 and 1 are privileged: they skip the table, always succeed and see virtual page x as physical page x.

A configuration port lets a privileged process rewrite any slot or choose one of three page sizes. An attempt by an unprivileged process to configure is dropped and flagged for one cycle. The `INSTR_SIDE` parameter builds either a code-side instance, where unprivileged processes may only read, or a data-side instance, where they may read and write.

The response path is a three-state machine. `RS_IDLE` means no response this cycle, `RS_GRANT` means a valid physical address is presented, and `RS_FAULT` means the access was refused. From any state it moves to `RS_IDLE` when no request arrives, to `RS_FAULT` when the request is refused, and to `RS_GRANT` otherwise.

Top module: `ipt_mmu`

## Requirements
- R1: After reset every slot holds rights code 0 and a virtual page equal to its own slot number, and the page size code is 0. Unprivileged accesses then fault, and the outputs are idle.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: For process IDs 0 and 1, reads and writes never fault, and the physical page equals the virtual page field of the address (identity mapping).
- R4: For process IDs 2 to 7, the physical page is the lowest slot number whose virtual page field (entry bits [3:0]) equals the request's virtual page and whose rights admit the process.
- R5: Rights code in entry bits [6:4]: 0 admits none of processes 2 to 7, 1 admits all of them, and 2 to 7 admit only the process whose ID equals the code.
- R6: When no slot both matches and admits an unprivileged process, `rsp_fault` is high and `rsp_paddr` is zero.
- R7: With `INSTR_SIDE`=1 any write by process 2 to 7 faults, while its reads translate normally. With `INSTR_SIDE`=0 its writes translate like reads.
- R8: Configuration address 16 sets the page size from `cfg_wdata[1:0]`. Code 0 gives 11 offset bits, code 1 gives 12, and codes 2 and 3 give 13. The offset bits pass through unchanged, the 4-bit virtual page is taken from the bits just above them, and address bits above that field are dropped.
- R9: A configuration write from process 0 or 1 to address 0 to 15 loads that slot with `cfg_wdata[6:0]`. Requests from the next cycle onward use the new contents.
- R10: A configuration write from process 2 to 7 changes neither the table nor the page size, and raises `cfg_viol` for exactly the following cycle.
- R11: A request issued in the same cycle as a privileged configuration write is translated with the table and page size as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_pid | input | 3 | Process ID of the access |
| req_vaddr | input | 17 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_fault | output | 1 | Access refused |
| rsp_paddr | output | 17 | Physical address, zero on fault |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pid | input | 3 | Process ID issuing the configuration write |
| cfg_addr | input | 5 | 0 to 15 select a slot, 16 the page size |
| cfg_wdata | input | 7 | Slot contents {rights[2:0], vpn[3:0]} or page size in [1:0] |
| cfg_viol | output | 1 | One-cycle flag for a refused configuration write |

## Verification
The lookup and the configuration write share a clock edge, so a request and a table or page-size write can land in the same cycle. The bench provokes this deliberately: it rewrites the very slot a pending request depends on, and it also lets the random stream collide writes with requests. The expected response is always computed from the bench's table model before that cycle's write is applied. A response that reflects the new rights or size one cycle early is judged a failure, and so is a second response that does not reflect them.

// File: rtl/ipt_mmu_pkg.sv
package ipt_mmu_pkg;

    localparam int PID_W         = 3;
    localparam int VPN_W         = 4;
    localparam int N_PAGES       = 1 << VPN_W;
    localparam int RIGHTS_W      = 3;
    localparam int ENTRY_W       = VPN_W + RIGHTS_W;
    localparam int OFS_MIN       = 11;
    localparam int N_SIZES       = 3;
    localparam int SIZE_W        = 2;
    localparam int VA_W          = VPN_W + OFS_MIN + N_SIZES - 1;
    localparam int SH_W          = $clog2(VA_W + 1);
    localparam int CFG_A_W       = $clog2(N_PAGES) + 1;
    localparam int SIZE_REG_ADDR = N_PAGES;
    localparam int PRIV_PIDS     = 2;

    localparam logic [RIGHTS_W-1:0] RIGHTS_NONE = RIGHTS_W'(0);
    localparam logic [RIGHTS_W-1:0] RIGHTS_ALL  = RIGHTS_W'(1);

    typedef struct packed {
        logic [RIGHTS_W-1:0] rights;
        logic [VPN_W-1:0]    vpn;
    } entry_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_GRANT = 2'd1,
        RS_FAULT = 2'd2
    } rsp_state_t;

    function automatic logic is_priv(input logic [PID_W-1:0] pid);
        return pid < PID_W'(PRIV_PIDS);
    endfunction

    function automatic logic rights_admit(input logic [RIGHTS_W-1:0] code,
                                          input logic [PID_W-1:0]    pid);
        if (code == RIGHTS_NONE) return 1'b0;
        if (code == RIGHTS_ALL)  return 1'b1;
        return code == pid;
    endfunction

endpackage

// File: rtl/ipt_table.sv
module ipt_table
    import ipt_mmu_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [PID_W-1:0]           cfg_pid,
    input  logic [CFG_A_W-1:0]         cfg_addr,
    input  logic [ENTRY_W-1:0]         cfg_wdata,
    output entry_t [N_PAGES-1:0]       tbl_o,
    output logic [SIZE_W-1:0]          size_o,
    output logic                       viol_o
);

    entry_t [N_PAGES-1:0] tbl_q;
    logic [SIZE_W-1:0]    size_q;
    logic                 viol_q;
    logic                 wr_ok;
    logic                 wr_bad;

    assign wr_ok  = cfg_we &&  is_priv(cfg_pid);
    assign wr_bad = cfg_we && !is_priv(cfg_pid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PAGES; i++) begin
                tbl_q[i].rights <= RIGHTS_NONE;
                tbl_q[i].vpn    <= VPN_W'(i);
            end
            size_q <= '0;
            viol_q <= 1'b0;
        end else begin
            viol_q <= wr_bad;
            if (wr_ok) begin
                for (int i = 0; i < N_PAGES; i++) begin
                    if (cfg_addr == CFG_A_W'(i)) begin
                        tbl_q[i] <= entry_t'(cfg_wdata);
                    end
                end
                if (cfg_addr == CFG_A_W'(SIZE_REG_ADDR)) begin
                    size_q <= cfg_wdata[SIZE_W-1:0];
                end
            end
        end
    end

    assign tbl_o  = tbl_q;
    assign size_o = size_q;
    assign viol_o = viol_q;

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
    import ipt_mmu_pkg::*;
#(
    parameter bit INSTR_SIDE = 1'b0
) (
    input  entry_t [N_PAGES-1:0]   tbl,
    input  logic [SIZE_W-1:0]      size,
    input  logic [PID_W-1:0]       pid,
    input  logic [VA_W-1:0]        vaddr,
    input  logic                   write,
    output logic                   fault,
    output logic [VA_W-1:0]        paddr
);

    logic [SH_W-1:0]    ofs;
    logic [VPN_W-1:0]   vpn;
    logic [VA_W-1:0]    off_mask;
    logic [VA_W-1:0]    offset;
    logic [N_PAGES-1:0] sel;
    logic               hit;
    logic [VPN_W-1:0]   ppn_found;
    logic [VPN_W-1:0]   ppn;
    logic               priv;
    logic               wr_block;

    // Offset width from the page-size code; codes past the last size saturate.
    always_comb begin
        if (size >= SIZE_W'(N_SIZES)) begin
            ofs = SH_W'(OFS_MIN + N_SIZES - 1);
        end else begin
            ofs = SH_W'(OFS_MIN) + SH_W'(size);
        end
    end

    assign vpn      = VPN_W'(vaddr >> ofs);
    assign off_mask = (VA_W'(1) << ofs) - VA_W'(1);
    assign offset   = vaddr & off_mask;

    // One comparator and rights check per physical slot.
    for (genvar g = 0; g < N_PAGES; g++) begin : g_slot
        assign sel[g] = (tbl[g].vpn == vpn) && rights_admit(tbl[g].rights, pid);
    end

    // Lowest slot number wins.
    always_comb begin
        hit       = 1'b0;
        ppn_found = '0;
        for (int i = N_PAGES - 1; i >= 0; i--) begin
            if (sel[i]) begin
                hit       = 1'b1;
                ppn_found = VPN_W'(i);
            end
        end
    end

    assign priv     = is_priv(pid);
    assign wr_block = INSTR_SIDE && write && !priv;
    assign ppn      = priv ? vpn : ppn_found;
    assign fault    = !priv && (wr_block || !hit);
    assign paddr    = fault ? '0 : ((VA_W'(ppn) << ofs) | offset);

endmodule

// File: rtl/ipt_resp_fsm.sv
module ipt_resp_fsm
    import ipt_mmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             fault_in,
    input  logic [VA_W-1:0]  paddr_in,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [VA_W-1:0]  rsp_paddr
);

    rsp_state_t      state_q;
    rsp_state_t      state_d;
    logic [VA_W-1:0] paddr_q;

    always_comb begin
        unique case (state_q)
            RS_IDLE, RS_GRANT, RS_FAULT: begin
                if (!req_valid)    state_d = RS_IDLE;
                else if (fault_in) state_d = RS_FAULT;
                else               state_d = RS_GRANT;
            end
            default:               state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= (req_valid && !fault_in) ? paddr_in : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE: begin
                rsp_valid = 1'b0;
                rsp_fault = 1'b0;
            end
            RS_GRANT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b0;
            end
            RS_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_fault = 1'b0;
            end
        endcase
    end

    assign rsp_paddr = paddr_q;

endmodule

// File: rtl/ipt_mmu.sv
module ipt_mmu
    import ipt_mmu_pkg::*;
#(
    parameter bit INSTR_SIDE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PID_W-1:0]    req_pid,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [VA_W-1:0]     rsp_paddr,
    input  logic                cfg_we,
    input  logic [PID_W-1:0]    cfg_pid,
    input  logic [CFG_A_W-1:0]  cfg_addr,
    input  logic [ENTRY_W-1:0]  cfg_wdata,
    output logic                cfg_viol
);

    entry_t [N_PAGES-1:0] tbl;
    logic [SIZE_W-1:0]    size;
    logic                 lk_fault;
    logic [VA_W-1:0]      lk_paddr;

    ipt_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_pid   (cfg_pid),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tbl_o     (tbl),
        .size_o    (size),
        .viol_o    (cfg_viol)
    );

    ipt_lookup #(.INSTR_SIDE(INSTR_SIDE)) u_lookup (
        .tbl   (tbl),
        .size  (size),
        .pid   (req_pid),
        .vaddr (req_vaddr),
        .write (req_write),
        .fault (lk_fault),
        .paddr (lk_paddr)
    );

    ipt_resp_fsm u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .fault_in  (lk_fault),
        .paddr_in  (lk_paddr),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/ipt_mmu_chk.sv
module ipt_mmu_chk
    import ipt_mmu_pkg::*;
#(
    parameter bit INSTR_SIDE = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [PID_W-1:0]     req_pid,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic                 rsp_fault,
    input logic [VA_W-1:0]      rsp_paddr,
    input logic                 cfg_we,
    input logic [PID_W-1:0]     cfg_pid,
    input logic                 cfg_viol,
    input entry_t [N_PAGES-1:0] tbl
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    priv_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pid < PID_W'(PRIV_PIDS)) |=> (rsp_valid && !rsp_fault));

    // R6
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

    // R7
    code_side_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (INSTR_SIDE && req_valid && req_write && req_pid >= PID_W'(PRIV_PIDS)) |=> rsp_fault);

    // R10
    viol_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_pid >= PID_W'(PRIV_PIDS)) |=> cfg_viol);

    // R10
    viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_pid >= PID_W'(PRIV_PIDS)) |=> !cfg_viol);

    // R10
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_pid >= PID_W'(PRIV_PIDS)) |=> $stable(tbl));

endmodule

bind ipt_mmu ipt_mmu_chk #(.INSTR_SIDE(INSTR_SIDE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pid   (req_pid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .cfg_we    (cfg_we),
    .cfg_pid   (cfg_pid),
    .cfg_viol  (cfg_viol),
    .tbl       (tbl)
);

// File: tb/test_ipt_mmu.sv
module test_ipt_mmu;
    import ipt_mmu_pkg::*;

    localparam int RW = VA_W + 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [PID_W-1:0]    req_pid = '0;
    logic [VA_W-1:0]     req_vaddr = '0;
    logic                req_write = 1'b0;
    logic                cfg_we = 1'b0;
    logic [PID_W-1:0]    cfg_pid = '0;
    logic [CFG_A_W-1:0]  cfg_addr = '0;
    logic [ENTRY_W-1:0]  cfg_wdata = '0;

    logic                d_valid, d_fault, d_viol;
    logic [VA_W-1:0]     d_paddr;
    logic                c_valid, c_fault, c_viol;
    logic [VA_W-1:0]     c_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_vpn [N_PAGES];
    int m_rt  [N_PAGES];
    int m_sz;

    always #4 clk = ~clk;

    ipt_mmu #(.INSTR_SIDE(1'b0)) i_ipt_mmu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
        .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(d_valid),
        .rsp_fault(d_fault), .rsp_paddr(d_paddr), .cfg_we(cfg_we),
        .cfg_pid(cfg_pid), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_viol(d_viol)
    );

    ipt_mmu #(.INSTR_SIDE(1'b1)) i_ipt_mmu_ins (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
        .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(c_valid),
        .rsp_fault(c_fault), .rsp_paddr(c_paddr), .cfg_we(cfg_we),
        .cfg_pid(cfg_pid), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_viol(c_viol)
    );

    function automatic int ofs_bits();
        return OFS_MIN + ((m_sz > N_SIZES - 1) ? N_SIZES - 1 : m_sz);
    endfunction

    function automatic int mk_va(input int vpn, input int off);
        int ob = ofs_bits();
        return (vpn << ob) | (off & ((1 << ob) - 1));
    endfunction

    function automatic bit admits(input int code, input int pid);
        if (code == 0) return 1'b0;
        if (code == 1) return 1'b1;
        return code == pid;
    endfunction

    // {fault, paddr} from the bench model.
    function automatic logic [VA_W:0] model_rsp(input int pid, input int va,
                                                 input bit wr, input bit code_side);
        int ob  = ofs_bits();
        int vpn = (va >> ob) & (N_PAGES - 1);
        int off = va & ((1 << ob) - 1);
        if (pid < PRIV_PIDS) return {1'b0, VA_W'((vpn << ob) | off)};
        if (code_side && wr) return {1'b1, VA_W'(0)};
        for (int i = 0; i < N_PAGES; i++) begin
            if (m_vpn[i] == vpn && admits(m_rt[i], pid)) return {1'b0, VA_W'((i << ob) | off)};
        end
        return {1'b1, VA_W'(0)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual {valid,fault,paddr,viol}=%h expected %h at %0t",
                     tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, check at the next falling edge.
    task automatic step(input bit v, input int pid, input int va, input bit wr,
                        input bit we, input int cpid, input int caddr, input int cwd,
                        input string tag);
        logic [RW-1:0] e_d, e_c, a_d, a_c;
        bit viol_e;
        req_valid = v;
        req_pid   = PID_W'(pid);
        req_vaddr = VA_W'(va);
        req_write = wr;
        cfg_we    = we;
        cfg_pid   = PID_W'(cpid);
        cfg_addr  = CFG_A_W'(caddr);
        cfg_wdata = ENTRY_W'(cwd);
        viol_e = we && (cpid >= PRIV_PIDS);
        e_d = v ? {1'b1, model_rsp(pid, va, wr, 1'b0), viol_e} : {2'b00, VA_W'(0), viol_e};
        e_c = v ? {1'b1, model_rsp(pid, va, wr, 1'b1), viol_e} : {2'b00, VA_W'(0), viol_e};
        @(negedge clk);
        a_d = {d_valid, d_fault, d_paddr, d_viol};
        a_c = {c_valid, c_fault, c_paddr, c_viol};
        chk(a_d === e_d, {tag, " data-side"}, a_d, e_d);
        chk(a_c === e_c, {tag, " code-side"}, a_c, e_c);
        if (we && cpid < PRIV_PIDS) begin
            if (caddr < N_PAGES) begin
                m_vpn[caddr] = cwd & (N_PAGES - 1);
                m_rt[caddr]  = (cwd >> VPN_W) & 7;
            end else if (caddr == SIZE_REG_ADDR) begin
                m_sz = cwd & 3;
            end
        end
        req_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    task automatic acc(input int pid, input int va, input bit wr, input string tag);
        step(1'b1, pid, va, wr, 1'b0, 0, 0, 0, tag);
    endtask

    task automatic cfg(input int cpid, input int caddr, input int cwd, input string tag);
        step(1'b0, 0, 0, 1'b0, 1'b1, cpid, caddr, cwd, tag);
    endtask

    function automatic int ent(input int rights, input int vpn);
        return (rights << VPN_W) | vpn;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual run still going expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N_PAGES; i++) begin
            m_vpn[i] = i;
            m_rt[i]  = 0;
        end
        m_sz = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle outputs after reset
        chk({d_valid, d_fault, d_viol, c_valid, c_fault, c_viol} == 6'b0, "R1 reset outputs",
            RW'({d_valid, d_fault, d_viol}), RW'(0));
        // R1: reset table denies every unprivileged process
        for (int p = 2; p < 8; p++) acc(p, mk_va(p + 3, 12'h5a5), 1'b0, "R1 reset rights");
        // R1: smallest page size, identity for privileged
        acc(0, 17'h1_2345, 1'b0, "R1 reset page size");

        // R3: privileged read and write, high bits dropped
        acc(1, 17'h1_fff0, 1'b1, "R3 privileged write");
        acc(0, 17'h0_7abc, 1'b0, "R3 privileged read");

        // R2: idle cycles give no response
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 0, "R2 idle");
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 0, "R2 idle");

        // R9, R5: slot 3 maps virtual page 9 for all unprivileged processes
        cfg(0, 3, ent(1, 9), "R9 slot write");
        acc(4, mk_va(9, 11'h123), 1'b0, "R9 new slot used");
        acc(7, mk_va(9, 11'h7ff), 1'b0, "R5 code 1 admits all");

        // R5: single-process code
        cfg(1, 7, ent(5, 2), "R9 slot write");
        acc(5, mk_va(2, 11'h044), 1'b0, "R5 matching pid admitted");
        acc(6, mk_va(2, 11'h044), 1'b0, "R5 other pid refused");
        acc(3, mk_va(11, 11'h001), 1'b0, "R6 no match faults");

        // R4: lowest admitting slot wins
        cfg(0, 10, ent(1, 12), "R9 slot write");
        cfg(0, 4, ent(1, 12), "R9 slot write");
        cfg(0, 1, ent(6, 12), "R9 slot write");
        acc(3, mk_va(12, 11'h3c3), 1'b0, "R4 lower refusing slot skipped");
        acc(6, mk_va(12, 11'h3c3), 1'b0, "R4 lowest admitting slot");

        // R7: writes by unprivileged processes
        acc(4, mk_va(9, 11'h222), 1'b1, "R7 unprivileged write");
        acc(4, mk_va(9, 11'h222), 1'b0, "R7 unprivileged read");

        // R8: each page size code
        for (int s = 1; s < 4; s++) begin
            cfg(0, SIZE_REG_ADDR, s, "R8 size write");
            acc(0, 17'h1_b6d9, 1'b0, "R8 privileged offset");
            acc(4, mk_va(9, 13'h1abc), 1'b0, "R8 unprivileged offset");
        end
        cfg(1, SIZE_REG_ADDR, 0, "R8 size write");

        // R10: refused configuration writes
        cfg(3, 3, ent(0, 0), "R10 unprivileged slot write");
        acc(4, mk_va(9, 11'h010), 1'b0, "R10 slot unchanged");
        cfg(7, SIZE_REG_ADDR, 2, "R10 unprivileged size write");
        acc(0, 17'h1_ffff, 1'b0, "R10 size unchanged");

        // R11: request in the same cycle as the write that revokes it
        step(1'b1, 4, mk_va(9, 11'h0f0), 1'b0, 1'b1, 0, 3, ent(0, 9), "R11 same-cycle write");
        acc(4, mk_va(9, 11'h0f0), 1'b0, "R11 following request");
        step(1'b1, 2, 17'h1_5555, 1'b0, 1'b1, 1, SIZE_REG_ADDR, 2, "R11 same-cycle size");
        acc(2, 17'h1_5555, 1'b0, "R11 following size");

        // Random mix with collisions
        for (int n = 0; n < 4000; n++) begin
            bit v   = ($urandom % 4) != 0;
            int pid = $urandom % 8;
            int va  = $urandom % (1 << VA_W);
            bit wr  = $urandom % 2;
            bit we  = ($urandom % 5) == 0;
            int cp  = ($urandom % 3 == 0) ? $urandom % 8 : $urandom % 2;
            int ca  = $urandom % 18;
            int cw  = $urandom % (1 << ENTRY_W);
            step(v, pid, va, wr, we, cp, ca, cw, "R4 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule